// File: doc/BRIEF.md
# Synchronous Late-Write Burst SRAM

This block is a synthesizable model of a synchronous static RAM that never needs an idle cycle on its data bus when traffic turns from reads to writes. Commands, addresses and byte strobes are sampled on rising clock edges where the clock enable is active (called enabled edges below). A write does not carry its data. The data follows one enabled edge later in flow-through mode, or two in pipelined mode, and it lands in the array from a small late-write stage. A read that lands on the same edge as such a commit, and at the same address, sees the freshly written bytes. This keeps commands in order without stalls.

A mode input chooses between pipelined and flow-through read timing. Bursts of four beats are kept by a two-bit beat counter. The counter steps the low address bits in linear order (modular add) or interleaved order (XOR). Three chip selects, per-lane write strobes for 9-bit lanes, an asynchronous output enable and an asynchronous sleep input complete the control set. The data output is shown as a value plus a drive flag. A low drive flag stands for high impedance, and the value then reads as zero.

Top module: `lw_burst_sram`

## Requirements
- R1: After reset, the drive flag is low, no burst is active and no read or write is pending.
- R2: A command with `ld_n` low is accepted only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination is a deselect: it writes nothing, returns nothing and ends the current burst.
- R3: With `flow_sel_n` high (pipelined), read data is driven after the first enabled edge that follows the read's own enabled edge.
- R4: With `flow_sel_n` low (flow-through), read data is driven right after the read's own enabled edge.
- R5: A write's lanes are taken from `wdata` two enabled edges after the command in pipelined mode, or one in flow-through mode. Only lanes whose `lane_wr_n` bit (bit i covers `wdata[9i+8:9i]`) was 0 at the command edge change.
- R6: Reads and writes may follow each other on consecutive edges with no idle edge. Every read returns the array contents with all earlier-issued writes applied, and no later-issued ones.
- R7: In a burst with `lin_order_n`=0, beat k (0..3, wrapping) addresses the upper bits of the loaded address joined with (low two bits + k) mod 4.
- R8: In a burst with `lin_order_n`=1, beat k addresses the upper bits joined with (low two bits XOR k).
- R9: `ld_n`=1 advances an active burst one beat and keeps its read or write type, whatever the chip selects are. With no active burst, it does nothing.
- R10: An edge with `clk_en_n`=1 is ignored completely. Burst state, pending writes, pending reads and the output all hold.
- R11: `out_en_n`=1 forces the drive flag low and the value to zero at once, between edges.
- R12: `sleep`=1 forces the drive flag low at once. A command sampled while `sleep` is high is a deselect. Writes already issued still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Edge enable, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read (on load) |
| lane_wr_n | input | BYTES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Late write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| flow_sel_n | input | 1 | 0 flow-through, 1 pipelined (static) |
| lin_order_n | input | 1 | 0 linear, 1 interleaved burst order (static) |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_drv | output | 1 | Output driven (low means high impedance) |

## Verification
The two functions that collide are a write's delayed data commit and a read whose output register loads on that same edge, at the same address. The read must carry the just-arrived lanes and not the stale word. This is provoked by read, write, read sequences to one address on consecutive edges in both modes. It is also provoked by long random traffic over a 64-word array with stalls, deselects and partial lane strobes mixed in. A behavioural model applies each commit to its own memory before it serves a read on the same edge, and the result is compared against the outputs every cycle.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
    typedef enum logic [0:0] {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } lwb_op_e;
endpackage

// File: rtl/lwb_addr_gen.sv
module lwb_addr_gen #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        beat_i,
    input  logic              linear_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [1:0] low;

    always_comb begin
        if (linear_i) low = base_i[1:0] + beat_i;
        else          low = base_i[1:0] ^ beat_i;
        addr_o = {base_i[ADDR_W-1:2], low};
    end
endmodule

// File: rtl/lwb_lane_merge.sv
module lwb_lane_merge #(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [BYTES-1:0]  keep_n_i,
    output logic [DATA_W-1:0] merged_o
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign merged_o[g*BYTE_W +: BYTE_W] = keep_n_i[g] ? old_i[g*BYTE_W +: BYTE_W]
                                                         : new_i[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/lwb_array.sv
module lwb_array #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9,
    localparam int DATA_W = BYTES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BYTES-1:0]  wlane_n_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && !wlane_n_i[g]) mem[waddr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
        end

        assign rdata_o[g*BYTE_W +: BYTE_W] = mem[raddr_i];
    end
endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram
    import lwb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9,
    localparam int DATA_W = BYTES * BYTE_W,
    localparam int LATE_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              ld_n,
    input  logic              wr_n,
    input  logic [BYTES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic              flow_sel_n,
    input  logic              lin_order_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv
);
    typedef struct packed {
        logic                          burst_act;
        lwb_op_e                       burst_op;
        logic [ADDR_W-1:0]             base;
        logic [1:0]                    beat;
        logic [LATE_N-1:0]             wp_v;
        logic [LATE_N-1:0][ADDR_W-1:0] wp_a;
        logic [LATE_N-1:0][BYTES-1:0]  wp_lane_n;
        logic                          rp_v;
        logic [ADDR_W-1:0]             rp_a;
        logic                          drv;
        logic [DATA_W-1:0]             dout;
    } lwb_state_t;

    lwb_state_t st_d, st_q;

    logic              flow;
    logic              chip_on;
    logic              cmd_v;
    lwb_op_e           cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              c_v;
    logic [ADDR_W-1:0] c_a;
    logic [BYTES-1:0]  c_lane_n;
    logic              r_v;
    logic [ADDR_W-1:0] r_a;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] fwd_word;
    logic              arr_we;
    logic              out_valid_q;
    logic              burst_act_q;
    logic              rd_pend_q;

    assign flow    = !flow_sel_n;
    assign chip_on = !sel0_n && sel1 && !sel2_n;

    // address of the command taken at this edge (uses next burst state)
    lwb_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .base_i   (st_d.base),
        .beat_i   (st_d.beat),
        .linear_i (!lin_order_n),
        .addr_o   (cmd_addr)
    );

    // late-write commit slot: stage 0 in flow-through, stage 1 in pipelined
    assign c_v      = flow ? st_q.wp_v[0]      : st_q.wp_v[LATE_N-1];
    assign c_a      = flow ? st_q.wp_a[0]      : st_q.wp_a[LATE_N-1];
    assign c_lane_n = flow ? st_q.wp_lane_n[0] : st_q.wp_lane_n[LATE_N-1];
    assign arr_we   = !clk_en_n && c_v;

    lwb_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
        .clk       (clk),
        .we_i      (arr_we),
        .waddr_i   (c_a),
        .wdata_i   (wdata),
        .wlane_n_i (c_lane_n),
        .raddr_i   (r_a),
        .rdata_o   (arr_word)
    );

    // forward lanes arriving on this edge into the read word
    lwb_lane_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_fwd (
        .old_i    (arr_word),
        .new_i    (wdata),
        .keep_n_i ((c_v && c_a == r_a) ? c_lane_n : {BYTES{1'b1}}),
        .merged_o (fwd_word)
    );

    always_comb begin
        st_d   = st_q;
        cmd_v  = 1'b0;
        cmd_op = OP_RD;

        // command decode and burst counter
        if (sleep) begin
            st_d.burst_act = 1'b0;
        end else if (!ld_n) begin
            if (chip_on) begin
                st_d.burst_act = 1'b1;
                st_d.burst_op  = wr_n ? OP_RD : OP_WR;
                st_d.base      = addr;
                st_d.beat      = 2'd0;
                cmd_v          = 1'b1;
                cmd_op         = wr_n ? OP_RD : OP_WR;
            end else begin
                st_d.burst_act = 1'b0;
            end
        end else if (st_q.burst_act) begin
            st_d.beat = st_q.beat + 2'd1;
            cmd_v     = 1'b1;
            cmd_op    = st_q.burst_op;
        end

        // late-write stages
        st_d.wp_v[0]      = cmd_v && (cmd_op == OP_WR);
        st_d.wp_a[0]      = cmd_addr;
        st_d.wp_lane_n[0] = lane_wr_n;
        for (int i = 1; i < LATE_N; i++) begin
            st_d.wp_v[i]      = st_q.wp_v[i-1];
            st_d.wp_a[i]      = st_q.wp_a[i-1];
            st_d.wp_lane_n[i] = st_q.wp_lane_n[i-1];
        end

        // read stage
        st_d.rp_v = cmd_v && (cmd_op == OP_RD);
        st_d.rp_a = cmd_addr;
        r_v       = flow ? (cmd_v && (cmd_op == OP_RD)) : st_q.rp_v;
        r_a       = flow ? cmd_addr : st_q.rp_a;

        st_d.drv = r_v;
        if (r_v) st_d.dout = fwd_word;

        if (clk_en_n) st_d = st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_drv   = st_q.drv && !out_en_n && !sleep;
    assign rdata       = rdata_drv ? st_q.dout : '0;
    assign out_valid_q = st_q.drv;
    assign burst_act_q = st_q.burst_act;
    assign rd_pend_q   = st_q.rp_v;
endmodule

// File: rtl/lwb_checker.sv
module lwb_checker #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              ld_n,
    input logic              wr_n,
    input logic              out_en_n,
    input logic              sleep,
    input logic              flow_sel_n,
    input logic              rdata_drv,
    input logic [DATA_W-1:0] rdata,
    input logic              out_valid_q,
    input logic              burst_act_q,
    input logic              rd_pend_q
);
    logic take;
    assign take = !clk_en_n && !sleep && !ld_n;

    AST_DESEL_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(!sel0_n && sel1 && !sel2_n)) |=> !burst_act_q); // R2
    AST_PIPE_READ_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !sel0_n && sel1 && !sel2_n && wr_n && flow_sel_n) |=> rd_pend_q); // R3
    AST_FLOW_READ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !sel0_n && sel1 && !sel2_n && wr_n && !flow_sel_n) |=> out_valid_q); // R4
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(out_valid_q) && $stable(burst_act_q) && $stable(rd_pend_q))); // R10
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_drv); // R11
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_drv |-> (rdata == '0)); // R11
    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_drv); // R12
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!out_valid_q && !burst_act_q && !rd_pend_q)); // R1

    logic unused_ok;
    assign unused_ok = wr_n;
endmodule

bind lw_burst_sram lwb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en_n    (clk_en_n),
    .sel0_n      (sel0_n),
    .sel1        (sel1),
    .sel2_n      (sel2_n),
    .ld_n        (ld_n),
    .wr_n        (wr_n),
    .out_en_n    (out_en_n),
    .sleep       (sleep),
    .flow_sel_n  (flow_sel_n),
    .rdata_drv   (rdata_drv),
    .rdata       (rdata),
    .out_valid_q (out_valid_q),
    .burst_act_q (burst_act_q),
    .rd_pend_q   (rd_pend_q)
);

// File: tb/sim_lw_burst_sram.sv
`timescale 1ns/1ps
module sim_lw_burst_sram;
    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic          ld_n = 1'b0, wr_n = 1'b1;
    logic [NB-1:0] lane_wr_n = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          out_en_n = 1'b0, sleep = 1'b0;
    logic          flow_sel_n = 1'b1, lin_order_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lw_burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .ld_n(ld_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
        .flow_sel_n(flow_sel_n), .lin_order_n(lin_order_n),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_mem [1 << AW];
    int            wq_a[$];
    int            wq_left[$];
    logic [NB-1:0] wq_lane[$];
    bit            rp_v;
    int            rp_a;
    bit            m_act, m_isw;
    int            m_base, m_beat;
    bit            m_drv;
    logic [DW-1:0] m_data;

    task automatic model_clear();
        wq_a.delete(); wq_left.delete(); wq_lane.delete();
        rp_v = 0; m_act = 0; m_drv = 0; m_data = '0;
    endtask

    task automatic model_step();
        bit go;
        int a, lo;
        if (clk_en_n) return;
        // late data arriving now lands first
        foreach (wq_left[i]) wq_left[i] = wq_left[i] - 1;
        if (wq_left.size() > 0 && wq_left[0] == 0) begin
            for (int b = 0; b < NB; b++)
                if (!wq_lane[0][b]) m_mem[wq_a[0]][b*BW +: BW] = wdata[b*BW +: BW];
            void'(wq_a.pop_front()); void'(wq_left.pop_front()); void'(wq_lane.pop_front());
        end
        m_drv = 0;
        if (rp_v) begin
            m_drv = 1; m_data = m_mem[rp_a]; rp_v = 0;
        end
        go = 0;
        if (sleep) m_act = 0;
        else if (!ld_n) begin
            if (!sel0_n && sel1 && !sel2_n) begin
                m_act = 1; m_isw = !wr_n; m_base = int'(addr); m_beat = 0; go = 1;
            end else m_act = 0;
        end else if (m_act) begin
            m_beat = (m_beat + 1) % 4; go = 1;
        end
        if (go) begin
            lo = lin_order_n ? ((m_base % 4) ^ m_beat) : ((m_base + m_beat) % 4);
            a  = (m_base / 4) * 4 + lo;
            if (m_isw) begin
                wq_a.push_back(a); wq_left.push_back(flow_sel_n ? 2 : 1); wq_lane.push_back(lane_wr_n);
            end else if (!flow_sel_n) begin
                m_drv = 1; m_data = m_mem[a];
            end else begin
                rp_v = 1; rp_a = a;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit            e_drv;
        logic [DW-1:0] e_dat;
        e_drv = m_drv && !out_en_n && !sleep;
        e_dat = e_drv ? m_data : '0;
        total++;
        if (rdata_drv !== e_drv || rdata !== e_dat) begin
            bad++;
            $display("FAIL %s: drv=%0b data=%h expected drv=%0b data=%h", tag, rdata_drv, rdata, e_drv, e_dat);
        end
    endtask

    task automatic tick(input string tag);
        wdata = DW'($urandom);
        model_step();
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic cmd_load(input bit wr, input int a);
        ld_n = 0; sel0_n = 0; sel1 = 1; sel2_n = 0; wr_n = !wr; addr = AW'(a); lane_wr_n = '0;
    endtask

    task automatic cmd_adv();
        ld_n = 1; lane_wr_n = '0;
    endtask

    task automatic cmd_idle();
        ld_n = 0; sel0_n = 1; sel1 = 1; sel2_n = 0;
    endtask

    task automatic do_reset(input bit flow_n);
        rst_n = 0; clk_en_n = 0; sleep = 0; out_en_n = 0; flow_sel_n = flow_n;
        cmd_idle();
        repeat (2) @(posedge clk);
        #1;
        model_clear();
        compare("R1 reset");
        rst_n = 1;
        tick("R1 first edge");
    endtask

    task automatic rand_cmd();
        clk_en_n  = ($urandom % 10) == 0;
        sleep     = ($urandom % 30) == 0;
        out_en_n  = ($urandom % 10) == 0;
        ld_n      = 1'($urandom);
        sel0_n    = ($urandom % 8) == 0;
        sel1      = ($urandom % 8) != 0;
        sel2_n    = ($urandom % 8) == 0;
        wr_n      = 1'($urandom);
        lane_wr_n = NB'($urandom);
        addr      = AW'($urandom);
    endtask

    task automatic rand_phase(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            rand_cmd();
            tick(tag);
        end
        clk_en_n = 0; sleep = 0; out_en_n = 0;
        cmd_idle();
        repeat (3) tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // pipelined, linear
        do_reset(1'b1);

        for (int b = 0; b < 16; b++) begin     // R5 fill with bursts, R7 linear order
            cmd_load(1, b * 4); tick("R5 fill load");
            for (int k = 0; k < 3; k++) begin cmd_adv(); tick("R7 fill advance"); end
        end
        cmd_idle(); repeat (3) tick("R5 drain");

        cmd_load(0, 5); tick("R3 read load");   // unaligned linear read burst
        for (int k = 0; k < 3; k++) begin cmd_adv(); tick("R7 linear read"); end
        cmd_idle(); repeat (2) tick("R3 read out");

        lin_order_n = 1;                          // R8 interleaved read/write bursts
        cmd_load(0, 6); tick("R8 load");
        for (int k = 0; k < 3; k++) begin cmd_adv(); tick("R8 interleaved read"); end
        cmd_load(1, 9); tick("R8 write load");
        for (int k = 0; k < 3; k++) begin cmd_adv(); tick("R8 interleaved write"); end
        cmd_load(0, 9); tick("R8 readback");
        for (int k = 0; k < 3; k++) begin cmd_adv(); tick("R8 readback"); end
        cmd_idle(); repeat (2) tick("R8 out");
        lin_order_n = 0;

        cmd_load(0, 9); tick("R6 read");         // read-write-read, same word
        cmd_load(1, 9); tick("R6 write");
        cmd_load(0, 9); tick("R6 read after write");
        cmd_load(0, 9); tick("R6 read forwarded");
        cmd_load(1, 9); tick("R6 write again");
        cmd_load(0, 9); tick("R6 read");
        cmd_idle(); repeat (3) tick("R6 out");

        cmd_load(1, 12); lane_wr_n = 2'b10; tick("R5 lane 0 only");
        cmd_load(1, 13); lane_wr_n = 2'b11; tick("R5 no lanes");
        cmd_idle(); repeat (2) tick("R5 drain");
        cmd_load(0, 12); tick("R5 read"); cmd_load(0, 13); tick("R5 read");
        cmd_idle(); repeat (2) tick("R5 out");

        for (int k = 0; k < 3; k++) begin        // R2 each select off, R9 advance dead
            cmd_load(1, 20);
            if (k == 0) sel0_n = 1; else if (k == 1) sel1 = 0; else sel2_n = 1;
            tick("R2 deselect");
            cmd_adv(); tick("R9 advance without burst");
        end
        cmd_load(0, 16); tick("R9 read"); cmd_adv(); sel0_n = 1; tick("R9 adv ignores selects");
        cmd_load(0, 20); tick("R2 read"); cmd_idle(); repeat (2) tick("R2 unchanged");

        cmd_load(0, 40); tick("R10 load");       // stall mid-burst
        clk_en_n = 1; cmd_load(1, 3);
        repeat (3) tick("R10 stalled");
        clk_en_n = 0;
        for (int k = 0; k < 3; k++) begin cmd_adv(); tick("R10 resume"); end
        cmd_load(1, 44); tick("R10 write");
        clk_en_n = 1; repeat (2) tick("R10 stall write");
        clk_en_n = 0; cmd_idle(); repeat (3) tick("R10 drain");
        cmd_load(0, 44); tick("R10 read"); cmd_idle(); repeat (2) tick("R10 out");

        cmd_load(0, 3); tick("R11 load"); cmd_idle(); tick("R11 driven");
        #1 out_en_n = 1; #0.5 compare("R11 oe off mid-cycle");
        #0.5 out_en_n = 0; #0.5 compare("R11 oe back on");
        sleep = 1; #0.3 compare("R12 sleep mid-cycle");
        sleep = 0; #0.2;
        tick("R11 idle");

        cmd_load(1, 50); tick("R12 write");       // write completes through sleep
        sleep = 1; cmd_load(0, 50); tick("R12 sleeping command");
        tick("R12 sleeping");
        sleep = 0; cmd_load(0, 50); tick("R12 read"); cmd_idle(); repeat (2) tick("R12 out");

        rand_phase(1500, "R6 pipelined random");

        // flow-through
        do_reset(1'b0);
        cmd_load(0, 7); tick("R4 read now");
        cmd_load(1, 7); tick("R4 write");
        cmd_load(0, 7); tick("R6 flow read after write");
        cmd_load(0, 7); tick("R4 read");
        cmd_idle(); repeat (2) tick("R4 idle");
        lin_order_n = 1;
        rand_phase(700, "R4 flow random interleaved");
        lin_order_n = 0;
        rand_phase(700, "R4 flow random linear");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule